// File: doc/BRIEF.md
# Sparse Weight Group Decompressor

The decompressor turns a sparsely encoded weight image back into a dense stream of weight elements. Three streams arrive at once. The first carries one 32-bit byte count per kernel group. The second carries presence bits, one bit per weight element. The third carries the surviving nonzero weight bytes, packed back to back. For every element of a group the block reads the next presence bit. A set bit pulls the next element from the packed stream. A clear bit stands for an element that was removed as zero, so the block emits zero in its place.

Elements are one byte wide in 8-bit integer mode and two bytes wide in 16-bit (integer or half-float) mode. The output carries one element per beat, 16 bits wide. At the end of each group the block compares the nonzero bytes it actually consumed with the group's stated byte count and records any mismatch. Software, or an upstream sequencer, loads the job settings and pulses `start`. The block then works through the configured number of groups and raises `done`.

Top module: `sparse_wdec`

## Requirements
- R1: After reset, `out_valid`, `done`, `err` and `size_ready` are all 0 until `start` is pulsed.
- R2: In 8-bit mode a set presence bit emits the next packed byte zero-extended to 16 bits (bits 15:8 are 0). Packed bytes are taken little-endian from each 32-bit word, byte 0 in bits 7:0 first.
- R3: A clear presence bit emits the value 0 and consumes no packed data.
- R4: In 16-bit mode (`cfg_wide`=1) a set bit emits one two-byte element. The earlier byte of the packed stream is the low byte, and the element takes 2 bytes from the packed stream.
- R5: Presence bits are taken from each 32-bit mask word starting at bit 0 and moving up to bit 31.
- R6: Each group emits exactly `cfg_grp_elems` elements (at least 1). The group's byte count is read from the size stream before the group's first element.
- R7: Packed data continues across group boundaries with no gap or padding. A group may end in the middle of a packed word.
- R8: With `cfg_align`=1, any unused bits left in a mask word at the end of a group are discarded, and the next group starts at bit 0 of a fresh mask word.
- R9: With `cfg_align`=0, unused mask bits carry over, and the next group continues in the same mask word.
- R10: If the bytes consumed for a group differ from that group's byte count, `err` rises at the group's end and stays high until the next `start`.
- R11: `done` rises after the last element of the last group is accepted, and stays high with `out_valid` low until the next `start`.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a job, samples the configuration, and flushes held words |
| cfg_wide | input | 1 | 1 selects two-byte elements, 0 selects one-byte elements |
| cfg_align | input | 1 | 1 drops leftover mask bits at group ends |
| cfg_grp_elems | input | 16 | Elements per group |
| cfg_num_grps | input | 16 | Groups in the job |
| size_valid | input | 1 | Group byte count offered |
| size_ready | output | 1 | Group byte count accepted |
| size_data | input | 32 | Group byte count |
| mask_valid | input | 1 | Mask word offered |
| mask_ready | output | 1 | Mask word accepted |
| mask_data | input | 32 | Presence bits |
| pk_valid | input | 1 | Packed word offered |
| pk_ready | output | 1 | Packed word accepted |
| pk_data | input | 32 | Packed nonzero bytes |
| out_valid | output | 1 | Element available |
| out_ready | input | 1 | Element taken |
| out_data | output | 16 | Element value |
| done | output | 1 | Job complete |
| err | output | 1 | Sticky byte-count mismatch |

## Verification
The assertions assume the configuration stays steady after `start`, and that `start` is pulsed only while no stream transfer is pending. They also assume that in 16-bit mode each group's packed data is a whole number of two-byte elements, which keeps the read position on even bytes. The bench builds every job from a list of presence bits and nonzero values that it generates itself, so the streams always hold exactly the data the job needs. It fills the stream queues only after the start pulse ends. It throttles `out_ready` at random to exercise back-pressure. The only deliberate break in consistency is one group's byte count, which is raised by one to provoke the error flag.

// File: rtl/sparse_wdec_pkg.sv
package sparse_wdec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SIZE = 2'd1,
    ST_RUN  = 2'd2,
    ST_DONE = 2'd3
  } wdec_state_e;
endpackage

// File: rtl/sparse_wdec_mask.sv
module sparse_wdec_mask #(
  parameter int MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [MASK_W-1:0] in_word,
  input  logic              take,
  input  logic              drop,
  output logic              bit_avail,
  output logic              bit_val
);
  localparam int PTR_W = $clog2(MASK_W);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MASK_W - 1);

  logic [MASK_W-1:0] word_q;
  logic              have_q, have_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              load;

  assign in_ready  = !have_q && !flush;
  assign load      = in_valid && in_ready;
  assign bit_avail = have_q;
  assign bit_val   = word_q[ptr_q];

  always_comb begin
    have_d = have_q;
    ptr_d  = ptr_q;
    if (flush) begin
      have_d = 1'b0;
      ptr_d  = '0;
    end else if (load) begin
      have_d = 1'b1;
      ptr_d  = '0;
    end else if (take) begin
      if (drop || ptr_q == PTR_LAST) begin
        have_d = 1'b0;
        ptr_d  = '0;
      end else begin
        ptr_d = ptr_q + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      have_q <= have_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) word_q <= in_word;
  end

  assert_take_needs_bit_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    take |-> have_q);
endmodule

// File: rtl/sparse_wdec_bytes.sv
module sparse_wdec_bytes #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              flush,
  input  logic              wide,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_word,
  input  logic              take,
  output logic              avail,
  output logic [15:0]       elem
);
  localparam int BYTES = DATA_W / 8;
  localparam int BP_W  = $clog2(BYTES);

  logic [DATA_W-1:0] word_q;
  logic              have_q, have_d;
  logic [BP_W-1:0]   ptr_q, ptr_d, ptr_hi;
  logic [BP_W:0]     ptr_sum;
  logic              load;
  logic [7:0]        lo_byte, hi_byte;

  assign in_ready = !have_q && !flush;
  assign load     = in_valid && in_ready;
  assign avail    = have_q;
  assign ptr_hi   = ptr_q + BP_W'(1);
  assign lo_byte  = word_q[{ptr_q, 3'b000} +: 8];
  assign hi_byte  = word_q[{ptr_hi, 3'b000} +: 8];
  assign elem     = wide ? {hi_byte, lo_byte} : {8'h00, lo_byte};
  assign ptr_sum  = {1'b0, ptr_q} + (wide ? (BP_W+1)'(2) : (BP_W+1)'(1));

  always_comb begin
    have_d = have_q;
    ptr_d  = ptr_q;
    if (flush) begin
      have_d = 1'b0;
      ptr_d  = '0;
    end else if (load) begin
      have_d = 1'b1;
      ptr_d  = '0;
    end else if (take) begin
      if (ptr_sum >= (BP_W+1)'(BYTES)) begin
        have_d = 1'b0;
        ptr_d  = '0;
      end else begin
        ptr_d = ptr_sum[BP_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      have_q <= have_d;
      ptr_q  <= ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) word_q <= in_word;
  end

  assert_take_needs_word_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    take |-> have_q);
  assert_even_offset_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (have_q && wide) |-> !ptr_q[0]);
endmodule

// File: rtl/sparse_wdec_ctrl.sv
module sparse_wdec_ctrl
  import sparse_wdec_pkg::*;
#(
  parameter int SIZE_W = 32,
  parameter int ELEM_W = 16,
  parameter int GRP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              start,
  input  logic              cfg_wide,
  input  logic              cfg_align,
  input  logic [ELEM_W-1:0] cfg_grp_elems,
  input  logic [GRP_W-1:0]  cfg_num_grps,
  input  logic              size_valid,
  output logic              size_ready,
  input  logic [SIZE_W-1:0] size_data,
  input  logic              elem_fire,
  input  logic              elem_nz,
  output logic              run,
  output logic              last_elem,
  output logic              wide,
  output logic              align,
  output logic              done,
  output logic              err
);
  wdec_state_e       state_q, state_d;
  logic [ELEM_W-1:0] elem_q, elem_d, gel_q, gel_d;
  logic [GRP_W-1:0]  grp_q, grp_d, ngr_q, ngr_d;
  logic [SIZE_W-1:0] bytes_q, bytes_d, size_q, size_d, add, bytes_sum;
  logic              err_q, err_d, wide_q, wide_d, align_q, align_d;
  logic              last_grp;

  assign run        = (state_q == ST_RUN);
  assign size_ready = (state_q == ST_SIZE) && !start;
  assign last_elem  = (elem_q == gel_q - ELEM_W'(1));
  assign last_grp   = (grp_q == ngr_q - GRP_W'(1));
  assign add        = elem_nz ? (wide_q ? SIZE_W'(2) : SIZE_W'(1)) : '0;
  assign bytes_sum  = bytes_q + add;
  assign wide       = wide_q;
  assign align      = align_q;
  assign done       = (state_q == ST_DONE);
  assign err        = err_q;

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    grp_d   = grp_q;
    bytes_d = bytes_q;
    size_d  = size_q;
    err_d   = err_q;
    gel_d   = gel_q;
    ngr_d   = ngr_q;
    wide_d  = wide_q;
    align_d = align_q;
    if (start) begin
      gel_d   = cfg_grp_elems;
      ngr_d   = cfg_num_grps;
      wide_d  = cfg_wide;
      align_d = cfg_align;
      err_d   = 1'b0;
      grp_d   = '0;
      elem_d  = '0;
      bytes_d = '0;
      state_d = (cfg_num_grps == '0) ? ST_DONE : ST_SIZE;
    end else begin
      case (state_q)
        ST_SIZE: begin
          if (size_valid) begin
            size_d  = size_data;
            elem_d  = '0;
            bytes_d = '0;
            state_d = ST_RUN;
          end
        end
        ST_RUN: begin
          if (elem_fire) begin
            if (last_elem) begin
              if (bytes_sum != size_q) err_d = 1'b1;
              grp_d   = grp_q + GRP_W'(1);
              state_d = last_grp ? ST_DONE : ST_SIZE;
            end else begin
              elem_d  = elem_q + ELEM_W'(1);
              bytes_d = bytes_sum;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      grp_q   <= '0;
      bytes_q <= '0;
      size_q  <= '0;
      err_q   <= 1'b0;
      gel_q   <= '0;
      ngr_q   <= '0;
      wide_q  <= 1'b0;
      align_q <= 1'b0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      grp_q   <= grp_d;
      bytes_q <= bytes_d;
      size_q  <= size_d;
      err_q   <= err_d;
      gel_q   <= gel_d;
      ngr_q   <= ngr_d;
      wide_q  <= wide_d;
      align_q <= align_d;
    end
  end

  assert_elem_bound_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (elem_q < gel_q));
  assert_err_at_group_end_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(err_q) |-> ($past(state_q) == ST_RUN));
endmodule

// File: rtl/sparse_wdec.sv
module sparse_wdec #(
  parameter int MASK_W = 32,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 32,
  parameter int ELEM_W = 16,
  parameter int GRP_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_wide,
  input  logic              cfg_align,
  input  logic [ELEM_W-1:0] cfg_grp_elems,
  input  logic [GRP_W-1:0]  cfg_num_grps,
  input  logic              size_valid,
  output logic              size_ready,
  input  logic [SIZE_W-1:0] size_data,
  input  logic              mask_valid,
  output logic              mask_ready,
  input  logic [MASK_W-1:0] mask_data,
  input  logic              pk_valid,
  output logic              pk_ready,
  input  logic [DATA_W-1:0] pk_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [15:0]       out_data,
  output logic              done,
  output logic              err
);
  logic [1:0]  rst_sync_q;
  logic        rst_ni;
  logic        run, last_elem, wide, align;
  logic        bit_avail, bit_val, pk_avail, fire;
  logic [15:0] pk_elem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign out_valid = run && bit_avail && (!bit_val || pk_avail);
  assign fire      = out_valid && out_ready;
  assign out_data  = bit_val ? pk_elem : 16'h0000;

  sparse_wdec_ctrl #(.SIZE_W(SIZE_W), .ELEM_W(ELEM_W), .GRP_W(GRP_W)) u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .start(start),
    .cfg_wide(cfg_wide), .cfg_align(cfg_align),
    .cfg_grp_elems(cfg_grp_elems), .cfg_num_grps(cfg_num_grps),
    .size_valid(size_valid), .size_ready(size_ready), .size_data(size_data),
    .elem_fire(fire), .elem_nz(bit_val),
    .run(run), .last_elem(last_elem), .wide(wide), .align(align),
    .done(done), .err(err)
  );

  sparse_wdec_mask #(.MASK_W(MASK_W)) u_mask (
    .clk(clk), .rst_ni(rst_ni), .flush(start),
    .in_valid(mask_valid), .in_ready(mask_ready), .in_word(mask_data),
    .take(fire), .drop(align && last_elem),
    .bit_avail(bit_avail), .bit_val(bit_val)
  );

  sparse_wdec_bytes #(.DATA_W(DATA_W)) u_bytes (
    .clk(clk), .rst_ni(rst_ni), .flush(start), .wide(wide),
    .in_valid(pk_valid), .in_ready(pk_ready), .in_word(pk_data),
    .take(fire && bit_val), .avail(pk_avail), .elem(pk_elem)
  );

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));
  assert_narrow_zext_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !wide) |-> (out_data[15:8] == 8'h00));
  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !out_valid);
endmodule

// File: tb/sparse_wdec_test.sv
`timescale 1ns/1ps
module sparse_wdec_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cfg_wide, cfg_align;
  logic [15:0] cfg_grp_elems, cfg_num_grps;
  logic        size_valid, size_ready, mask_valid, mask_ready, pk_valid, pk_ready;
  logic [31:0] size_data, mask_data, pk_data;
  logic        out_valid, out_ready, done, err;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R2";

  logic [15:0] exp_q[$];
  logic [31:0] mask_q[$], pk_q[$], size_q[$];
  logic [31:0] macc, pacc;
  int midx, pidx;

  always #2 clk = ~clk;

  sparse_wdec uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_wide(cfg_wide), .cfg_align(cfg_align),
    .cfg_grp_elems(cfg_grp_elems), .cfg_num_grps(cfg_num_grps),
    .size_valid(size_valid), .size_ready(size_ready), .size_data(size_data),
    .mask_valid(mask_valid), .mask_ready(mask_ready), .mask_data(mask_data),
    .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_data(pk_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // stream drivers
  initial begin : feed_mask
    bit acc = 0;
    mask_valid = 0; mask_data = '0;
    forever begin
      @(negedge clk);
      if (mask_valid && acc) mask_valid = 0;
      if (!mask_valid && mask_q.size() > 0) begin mask_data = mask_q.pop_front(); mask_valid = 1; end
      acc = mask_valid && mask_ready;
    end
  end
  initial begin : feed_pk
    bit acc = 0;
    pk_valid = 0; pk_data = '0;
    forever begin
      @(negedge clk);
      if (pk_valid && acc) pk_valid = 0;
      if (!pk_valid && pk_q.size() > 0) begin pk_data = pk_q.pop_front(); pk_valid = 1; end
      acc = pk_valid && pk_ready;
    end
  end
  initial begin : feed_size
    bit acc = 0;
    size_valid = 0; size_data = '0;
    forever begin
      @(negedge clk);
      if (size_valid && acc) size_valid = 0;
      if (!size_valid && size_q.size() > 0) begin size_data = size_q.pop_front(); size_valid = 1; end
      acc = size_valid && size_ready;
    end
  end

  // monitor / scoreboard
  initial begin : monitor
    bit prev_stall = 0;
    logic [15:0] prev_data = '0;
    logic [15:0] e;
    out_ready = 0;
    forever begin
      @(negedge clk);
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R12 hold", {15'b0, out_valid, out_data}, {16'h1, prev_data});
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, {cur_tag, " unexpected element"}, {16'h0, out_data}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(out_data == e, cur_tag, {16'h0, out_data}, {16'h0, e});
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  task automatic push_bit(input bit b);
    macc[midx] = b;
    midx++;
    if (midx == 32) begin mask_q.push_back(macc); macc = '0; midx = 0; end
  endtask

  task automatic push_byte(input logic [7:0] b);
    pacc[pidx*8 +: 8] = b;
    pidx++;
    if (pidx == 4) begin pk_q.push_back(pacc); pacc = '0; pidx = 0; end
  endtask

  // mode: 0 random, 1 all clear, 2 all set
  task automatic run_job(input bit wide, input bit align, input int elems, input int ngrps,
                         input int mode, input int bad_grp, input string tag);
    logic [15:0] v;
    bit b;
    int nz;
    cur_tag = tag;
    @(negedge clk);
    cfg_wide = wide; cfg_align = align;
    cfg_grp_elems = 16'(elems); cfg_num_grps = 16'(ngrps);
    start = 1;
    @(negedge clk);
    start = 0;
    check(done == 0 && out_valid == 0, "R11 done clears on start", {30'b0, done, out_valid}, 32'h0);
    macc = '0; pacc = '0; midx = 0; pidx = 0;
    for (int g = 0; g < ngrps; g++) begin
      nz = 0;
      for (int k = 0; k < elems; k++) begin
        b = (mode == 2) ? 1'b1 : (mode == 1) ? 1'b0 : 1'($urandom % 2);
        push_bit(b);
        if (b) begin
          v = wide ? 16'(($urandom % 65535) + 1) : 16'(($urandom % 255) + 1);
          push_byte(v[7:0]);
          if (wide) push_byte(v[15:8]);
          exp_q.push_back(v);
          nz++;
        end else begin
          exp_q.push_back(16'h0);
        end
      end
      size_q.push_back(32'(nz * (wide ? 2 : 1) + ((g == bad_grp) ? 1 : 0)));
      if (align && midx != 0) begin mask_q.push_back(macc); macc = '0; midx = 0; end
    end
    if (midx != 0) mask_q.push_back(macc);
    if (pidx != 0) pk_q.push_back(pacc);
    while (!done) @(negedge clk);
    check(exp_q.size() == 0, {tag, " R6 all elements emitted"}, 32'(exp_q.size()), 32'h0);
    check(err == (bad_grp >= 0), {tag, " R10 err flag"}, {31'b0, err}, {31'b0, bad_grp >= 0});
    repeat (4) @(negedge clk);
    check(done && !out_valid, "R11 done holds", {30'b0, done, out_valid}, 32'h2);
    exp_q.delete();
  endtask

  initial begin : main
    rst_n = 0; start = 0; cfg_wide = 0; cfg_align = 0;
    cfg_grp_elems = 16'd1; cfg_num_grps = 16'd1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!out_valid && !done && !err && !size_ready, "R1 reset state",
          {28'b0, out_valid, done, err, size_ready}, 32'h0);
    run_job(0, 0, 40, 3, 0, -1, "R2 R3 R5 R6 R7 R9 narrow carry");
    run_job(0, 1, 20, 3, 0, -1, "R2 R5 R8 narrow aligned");
    run_job(1, 0, 24, 3, 0, -1, "R4 R7 R9 wide carry");
    run_job(1, 1, 10, 2, 0, -1, "R4 R8 wide aligned");
    run_job(0, 0, 8, 2, 1, -1, "R3 R6 all clear");
    run_job(1, 0, 33, 2, 2, -1, "R4 R5 all set");
    run_job(0, 0, 12, 3, 0, 1, "R10 size mismatch");
    repeat (6) @(negedge clk);
    check(err == 1, "R10 err sticky", {31'b0, err}, 32'h1);
    run_job(0, 1, 9, 2, 0, -1, "R8 R10 err cleared by start");
    finish_run();
  end
endmodule